// File: doc/BRIEF.md
# Trim Wiper Register with Two-Wire Serial Slave

This block holds a 6-bit trim code (the wiper position of a programmable resistor ladder) and lets a two-wire serial bus master set and inspect it. SCL and SDA are oversampled on the system clock, and the block answers on SDA through an open-drain enable that pulls the line low while it is asserted. A write addresses the device, sends one instruction byte, then one or more data bytes. A read returns one byte that packs two fuse-status bits above the current code.

The instruction byte carries a single meaningful bit, the permanent-programming request. When it is set, every data byte that is accepted in that write raises a one-cycle program request toward an external fuse sequencer. The sequencer returns a 2-bit status and a lock flag. While the lock flag is high, data bytes are still acknowledged but leave the code untouched and raise no request.

Top module: `trim_wiper_i2c`

## Requirements
- R1: After reset the code output is 0x20 (midscale), the SDA enable is low and no program request is raised.
- R2: The 7-bit device address is binary 010110 followed by the `addr_sel` pin. The address byte is sent MSB first with the read/write flag as bit 0 (1 = read). A matching address byte is acknowledged by pulling SDA low during the ninth clock. A non-matching one gets no acknowledge, and SDA is not driven again before the next START.
- R3: In a write, the low six bits of a data byte load the code. Bits 7:6 of the data byte are ignored. The instruction byte and every data byte are acknowledged.
- R4: Further data bytes in the same write each load the code again, using the instruction already received.
- R5: When bit 7 of the instruction byte is 1, each accepted data byte produces exactly one single-cycle `prog_req` pulse. The pulse comes after that byte's acknowledge clock ends, and the code already holds the new value when it appears.
- R6: When instruction bit 7 is 0, no program request is raised whatever the other seven instruction bits hold.
- R7: A read returns, MSB first, `fuse_status[1]`, `fuse_status[0]`, then the 6-bit code from bit 5 down to bit 0. If the master acknowledges that byte, the same byte is sent again.
- R8: While `fuse_locked` is high, data bytes are acknowledged but do not change the code and raise no program request. A read still works.
- R9: STOP (SDA rising while SCL is high) returns the slave to idle, and bytes clocked afterwards without a START are not acknowledged. START (SDA falling while SCL is high) restarts address reception at any point, including in the middle of a write.
- R10: After the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Lowest device address bit |
| fuse_status | input | 2 | Status from the fuse sequencer, placed in read bits 7:6 |
| fuse_locked | input | 1 | High once the code has been permanently programmed |
| wiper_code | output | 6 | Current trim code |
| prog_req | output | 1 | One-cycle request to permanently program the code |

## Verification
The assertions assume a well-behaved master. Each SCL high and low phase lasts longer than the synchronizer delay plus one cycle. SDA changes only while SCL is low, except for START and STOP. The master never issues START or STOP while the slave is pulling SDA low. The bench's bus tasks hold each quarter bit for six system clocks. They move SDA only in the middle of the SCL-low phase and release SDA before each acknowledge or read bit. Under these conditions a change of the SDA enable always falls inside an SCL-low phase, and the stop-release and lock properties hold.

// File: rtl/trim_wiper_pkg.sv
package trim_wiper_pkg;
  localparam int CODE_W = 6;
  localparam int STAT_W = 2;
  localparam int BYTE_W = CODE_W + STAT_W;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [5:0] DEV_ID = 6'b010110;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_ACK, ST_TX, ST_MACK
  } frame_st_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic sel);
    return b[BYTE_W-1:1] == {DEV_ID, sel};
  endfunction

  function automatic logic [BYTE_W-1:0] read_word(input logic [STAT_W-1:0] st,
                                                  input logic [CODE_W-1:0] code);
    return {st, code};
  endfunction
endpackage

// File: rtl/trim_bus_sync.sv
module trim_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_prev, sda_prev, scl_lvl;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scl_chain[i] <= 1'b1;
        sda_chain[i] <= 1'b1;
      end else begin
        scl_chain[i] <= (i == 0) ? scl_raw : scl_chain[(i == 0) ? 0 : i-1];
        sda_chain[i] <= (i == 0) ? sda_raw : sda_chain[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign scl_lvl = scl_chain[STAGES-1];
  assign sda_lvl = sda_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/trim_frame_engine.sv
module trim_frame_engine
  import trim_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              addr_sel,
  input  logic [STAT_W-1:0] fuse_status,
  input  logic [CODE_W-1:0] cur_code,
  output logic              sda_oe,
  output logic              data_wr,
  output logic [CODE_W-1:0] data_code,
  output logic              prog_ask
);
  frame_st_t         state, ack_next;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_rdy, tbit, ack_data, rd_ack;

  assign data_code = shreg[CODE_W-1:0];
  assign data_wr   = scl_fall && byte_rdy && (state == ST_DATA);
  assign prog_ask  = scl_fall && (state == ST_ACK) && ack_data && tbit;
  assign sda_oe    = (state == ST_ACK) || ((state == ST_TX) && !shreg[BYTE_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_rdy <= 1'b0;
      tbit     <= 1'b0;
      ack_data <= 1'b0;
      rd_ack   <= 1'b0;
    end else if (bus_start) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      byte_rdy <= 1'b0;
    end else if (bus_stop) begin
      state    <= ST_IDLE;
      byte_rdy <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise && !byte_rdy) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(BYTE_W - 1)) byte_rdy <= 1'b1;
          end else if (scl_fall && byte_rdy) begin
            byte_rdy <= 1'b0;
            ack_data <= (state == ST_DATA);
            if (state == ST_ADDR) begin
              if (addr_hit(shreg, addr_sel)) begin
                state    <= ST_ACK;
                ack_next <= shreg[0] ? ST_TX : ST_INSTR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (state == ST_INSTR) tbit <= shreg[BYTE_W-1];
              state    <= ST_ACK;
              ack_next <= ST_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state  <= ack_next;
            bitcnt <= '0;
            if (ack_next == ST_TX) shreg <= read_word(fuse_status, cur_code);
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(BYTE_W - 1)) state <= ST_MACK;
            else shreg <= {shreg[BYTE_W-2:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            rd_ack <= !sda_lvl;
          end else if (scl_fall) begin
            if (rd_ack) begin
              state  <= ST_TX;
              bitcnt <= '0;
              shreg  <= read_word(fuse_status, cur_code);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_wiper_reg.sv
module trim_wiper_reg
  import trim_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              prog_ask,
  input  logic              locked,
  output logic [CODE_W-1:0] code,
  output logic              prog_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code     <= CODE_MID;
      prog_req <= 1'b0;
    end else begin
      if (wr_en && !locked) code <= wr_code;
      prog_req <= prog_ask && !locked;
    end
  end
endmodule

// File: rtl/trim_wiper_i2c.sv
module trim_wiper_i2c
  import trim_wiper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic [STAT_W-1:0] fuse_status,
  input  logic              fuse_locked,
  output logic [CODE_W-1:0] wiper_code,
  output logic              prog_req
);
  logic              sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic              data_wr, prog_ask;
  logic [CODE_W-1:0] data_code;

  trim_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  trim_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_sel(addr_sel), .fuse_status(fuse_status), .cur_code(wiper_code),
    .sda_oe(sda_oe), .data_wr(data_wr), .data_code(data_code), .prog_ask(prog_ask)
  );

  trim_wiper_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_code(data_code),
    .prog_ask(prog_ask), .locked(fuse_locked), .code(wiper_code), .prog_req(prog_req)
  );
endmodule

// File: rtl/trim_wiper_chk.sv
module trim_wiper_chk
  import trim_wiper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              bus_stop,
  input logic              data_wr,
  input logic              fuse_locked,
  input logic [CODE_W-1:0] wiper_code,
  input logic              prog_req
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  a_r5_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(sda_oe));

  a_r8_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_locked |=> $stable(wiper_code));

  a_r8_locked_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_locked |=> !prog_req);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);

  a_r2_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r3_code_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_code) |-> $past(data_wr));
endmodule

bind trim_wiper_i2c trim_wiper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .bus_stop(bus_stop),
  .data_wr(data_wr), .fuse_locked(fuse_locked), .wiper_code(wiper_code),
  .prog_req(prog_req)
);

// File: tb/tb_trim_wiper_i2c.sv
module tb_trim_wiper_i2c;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, fuse_locked = 1'b0;
  logic [1:0] fuse_status = 2'b00;
  logic sda_oe, prog_req, sda_line;
  logic [5:0] wiper_code;
  int tests = 0, fails = 0, prog_cnt = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_oe ? 1'b0 : m_sda;

  trim_wiper_i2c dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .fuse_status(fuse_status), .fuse_locked(fuse_locked),
    .wiper_code(wiper_code), .prog_req(prog_req)
  );

  always @(posedge clk) if (rst_n && prog_req) prog_cnt <= prog_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (6) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); ack = ~sda_line; q(); m_scl = 1'b0; q();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic [7:0] v;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q(); v[i] = sda_line; q(); m_scl = 1'b0;
    end
    q(); m_sda = ~give_ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    m_sda = 1'b1;
    b = v;
  endtask

  function automatic logic [7:0] dev_addr(input logic sel, input logic rd);
    return {6'b010110, sel, rd};
  endfunction

  task automatic read_frame(input logic sel, output logic [7:0] v, output logic ack);
    m_start(); put_byte(dev_addr(sel, 1'b1), ack); get_byte(1'b0, v); m_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] v, v2;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check(wiper_code == 6'h20, "R1 reset code", wiper_code, 6'h20);
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(prog_cnt == 0, "R1 no request", prog_cnt, 0);
    fuse_status = 2'b01;
    read_frame(1'b0, v, a0);
    check(v == 8'h60, "R1 midscale readback", v, 8'h60);

    // R3 R7 sweep of all codes, address select and status alternate
    for (int c = 0; c < 64; c++) begin
      logic [7:0] d;
      addr_sel = c[0];
      fuse_status = c[2:1];
      d = {c[5:4] ^ 2'b10, c[5:0]};
      m_start();
      put_byte(dev_addr(addr_sel, 1'b0), a0);
      put_byte({1'b0, c[6:0] ^ 7'h55}, a1);
      put_byte(d, a2);
      m_stop();
      check(a0 && a1 && a2, "R3 write acks", {a0, a1, a2}, 3'b111);
      check(wiper_code == c[5:0], "R3 code loaded", wiper_code, c[5:0]);
      read_frame(addr_sel, v, a0);
      check(a0, "R2 read address ack", a0, 1);
      check(v == {c[2:1], c[5:0]}, "R7 read byte", v, {c[2:1], c[5:0]});
      check(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
    end
    check(prog_cnt == 0, "R6 no request in sweep", prog_cnt, 0);

    // R2 wrong addresses: no ack, no effect
    addr_sel = 1'b0;
    m_start();
    put_byte(dev_addr(1'b1, 1'b0), a0);
    put_byte(8'h00, a1);
    put_byte(8'h05, a2);
    m_stop();
    check(!a0 && !a1 && !a2, "R2 select mismatch not acked", {a0, a1, a2}, 0);
    check(wiper_code == 6'h3F, "R2 code kept", wiper_code, 6'h3F);
    m_start();
    put_byte(8'b0101110_0, a0);
    put_byte(8'h09, a1);
    m_stop();
    check(!a0 && !a1, "R2 id mismatch not acked", {a0, a1}, 0);
    check(wiper_code == 6'h3F, "R2 code kept id", wiper_code, 6'h3F);

    // R4 several data bytes in one write
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    put_byte(8'h00, a0);
    put_byte(8'h05, a0);
    check(wiper_code == 6'h05, "R4 first data", wiper_code, 6'h05);
    put_byte(8'h3A, a0);
    check(wiper_code == 6'h3A, "R4 second data", wiper_code, 6'h3A);
    put_byte(8'hC7, a1);
    check(wiper_code == 6'h07 && a1, "R4 third data", wiper_code, 6'h07);
    m_stop();

    // R5 programming bit
    base = prog_cnt;
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    put_byte(8'h80, a0);
    put_byte(8'h11, a0);
    check(prog_cnt == base + 1, "R5 one pulse", prog_cnt, base + 1);
    check(wiper_code == 6'h11, "R5 code before pulse", wiper_code, 6'h11);
    put_byte(8'h12, a0);
    m_stop();
    check(prog_cnt == base + 2, "R5 pulse per data byte", prog_cnt, base + 2);

    // R6 other instruction bits do not request
    base = prog_cnt;
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    put_byte(8'h7F, a0);
    put_byte(8'h1C, a0);
    m_stop();
    check(prog_cnt == base, "R6 no pulse", prog_cnt, base);
    check(wiper_code == 6'h1C, "R6 code loaded", wiper_code, 6'h1C);

    // R8 locked
    fuse_locked = 1'b1;
    fuse_status = 2'b11;
    base = prog_cnt;
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    put_byte(8'h80, a1);
    put_byte(8'h2A, a2);
    m_stop();
    check(a0 && a1 && a2, "R8 locked still acked", {a0, a1, a2}, 3'b111);
    check(wiper_code == 6'h1C, "R8 code frozen", wiper_code, 6'h1C);
    check(prog_cnt == base, "R8 no pulse", prog_cnt, base);
    read_frame(1'b0, v, a0);
    check(v == 8'hDC, "R8 read while locked", v, 8'hDC);
    fuse_locked = 1'b0;
    fuse_status = 2'b10;

    // R9 repeated start into a read
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    put_byte(8'h00, a0);
    m_start();
    put_byte(dev_addr(1'b0, 1'b1), a1);
    get_byte(1'b0, v);
    m_stop();
    check(a1 && v == 8'h9C, "R9 repeated start read", v, 8'h9C);
    // R9 stop then bytes without start
    m_start();
    put_byte(dev_addr(1'b0, 1'b0), a0);
    m_stop();
    m_scl = 1'b0; q();
    put_byte(8'h00, a1);
    put_byte(8'h01, a2);
    check(!a1 && !a2, "R9 no ack after stop", {a1, a2}, 0);
    check(wiper_code == 6'h1C, "R9 code kept after stop", wiper_code, 6'h1C);
    m_stop();

    // R7 master ack repeats the byte; R10 nothing driven after nack
    m_start();
    put_byte(dev_addr(1'b0, 1'b1), a0);
    get_byte(1'b1, v);
    get_byte(1'b0, v2);
    check(v == 8'h9C && v2 == 8'h9C, "R7 repeated read byte", v2, 8'h9C);
    get_byte(1'b0, v);
    check(v == 8'hFF, "R10 idle after nack", v, 8'hFF);
    m_stop();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule